// File: doc/BRIEF.md
# Per-Region DRAM Activation and Precharge Delay Unit

This unit sits in a memory controller next to the command scheduler. It decides how long each bank must wait between an activate and the first read, and between a precharge and the next activate. It does not use one fixed figure for every access. The address space is split into regions. For each region a profile table holds two separate one-bit flags: one for the activate-to-read delay and one for the precharge-to-activate delay. The two flags are kept apart because the cells that are slow to activate and the cells that are slow to precharge are not in the same places. A region whose flag says it has no slow cells gets the short delay. Every other region gets the standard delay.

When an activate or a precharge is accepted, the unit looks up the region on the command. It loads that bank's countdown with the cycle count the flag selects. While the countdown is nonzero, the bank's ready output for the dependent command is held low. For a precharge, the region presented is the region of the row that will be opened next.

The controller fills the profile table and programs the four delay counts, so software never sees the mechanism. The suggested settings at a 2.5 ns clock are 4 cycles for fast and 6 cycles for standard. A table write applies only to commands accepted after it.

Top module: `region_timing_unit`

## Requirements
- R1: After synchronous reset every `rd_ready` and `act_ready` bit is 1, and every region is marked standard (both flags 0) for both delays.
- R2: An accepted activate (`cmd_valid`=1, `cmd_op`=2'b01) to a region whose activate flag is 1 holds `rd_ready[cmd_bank]` low for exactly `cfg_rcd_fast` cycles, starting the cycle after acceptance.
- R3: An accepted activate to a region whose activate flag is 0 holds `rd_ready[cmd_bank]` low for exactly `cfg_rcd_std` cycles.
- R4: An accepted precharge (`cmd_op`=2'b11) holds `act_ready[cmd_bank]` low for `cfg_rp_fast` cycles when the precharge flag of `cmd_region` is 1, and for `cfg_rp_std` cycles when it is 0. Here `cmd_region` is the region of the row to be opened next.
- R5: The two flags are independent. The activate flag has no effect on the precharge delay, and the precharge flag has no effect on the activate delay.
- R6: A command to one bank leaves the ready outputs of every other bank unchanged.
- R7: A profile write (`prof_we`=1, writing `prof_rcd_fast` and `prof_rp_fast` to region `prof_region`) affects only commands accepted in later cycles. A command in the same cycle sees the old flags, and a countdown already running keeps its length.
- R8: A selected delay of 0 cycles leaves the ready output high.
- R9: A read (2'b10), a no-op (2'b00), or any opcode presented with `cmd_valid`=0 changes no ready output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command accepted this cycle |
| cmd_op | input | 2 | 00 no-op, 01 activate, 10 read, 11 precharge |
| cmd_bank | input | BANK_W | Target bank |
| cmd_region | input | REG_W | Region of the row being opened (activate), or of the row to be opened next (precharge) |
| prof_we | input | 1 | Profile table write strobe |
| prof_region | input | REG_W | Region written |
| prof_rcd_fast | input | 1 | New activate flag (1 = fast) |
| prof_rp_fast | input | 1 | New precharge flag (1 = fast) |
| cfg_rcd_fast | input | CNT_W | Short activate-to-read count |
| cfg_rcd_std | input | CNT_W | Standard activate-to-read count |
| cfg_rp_fast | input | CNT_W | Short precharge-to-activate count |
| cfg_rp_std | input | CNT_W | Standard precharge-to-activate count |
| rd_ready | output | NUM_BANKS | Per bank: a read may issue |
| act_ready | output | NUM_BANKS | Per bank: an activate may issue |

## Verification
The bench measures, cycle by cycle, how long each ready output stays low, so a countdown that is off by one cycle in either direction is caught.

It sets the two flags of a region to opposite values. A design that shared one flag between the two delays, or that looked up the wrong flag, would then show the wrong length on one of the two delays.

It writes the profile table in the same cycle as a command, and again in the middle of a running countdown. A table that fed new flags straight to the lookup, or a counter reloaded by a write, would shorten the wait.

It also covers a zero-cycle delay, reads and invalid commands, and checks that an idle bank's ready outputs stay high. These catch counters that start without cause, a bank decode that is wrong, and a countdown that wraps from zero.

// File: rtl/rtu_pkg.sv
package rtu_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_ACT = 2'b01,
        OP_RD  = 2'b10,
        OP_PRE = 2'b11
    } cmd_op_t;

    typedef struct packed {
        logic rcd_fast;
        logic rp_fast;
    } region_prof_t;

    localparam int DEF_FAST_CYC = 4;
    localparam int DEF_STD_CYC  = 6;

    function automatic logic [7:0] pick_delay(input logic fast,
                                              input logic [7:0] fast_cyc,
                                              input logic [7:0] std_cyc);
        return fast ? fast_cyc : std_cyc;
    endfunction

endpackage

// File: rtl/rtu_profile_table.sv
module rtu_profile_table
    import rtu_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    localparam int REG_W = $clog2(NUM_REGIONS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [REG_W-1:0]   wr_idx,
    input  region_prof_t       wr_prof,
    input  logic [REG_W-1:0]   rd_idx,
    output region_prof_t       rd_prof
);

    region_prof_t entries [NUM_REGIONS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                entries[i] <= '0;
            end
        end else if (we) begin
            entries[wr_idx] <= wr_prof;
        end
    end

    // Read returns the registered contents, so a same-cycle write is not seen
    assign rd_prof = entries[rd_idx];

endmodule

// File: rtl/rtu_delay_counter.sv
module rtu_delay_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/region_timing_unit.sv
module region_timing_unit
    import rtu_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int NUM_REGIONS = 16,
    parameter int CNT_W       = 4,
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int REG_W  = $clog2(NUM_REGIONS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [REG_W-1:0]     cmd_region,
    input  logic                 prof_we,
    input  logic [REG_W-1:0]     prof_region,
    input  logic                 prof_rcd_fast,
    input  logic                 prof_rp_fast,
    input  logic [CNT_W-1:0]     cfg_rcd_fast,
    input  logic [CNT_W-1:0]     cfg_rcd_std,
    input  logic [CNT_W-1:0]     cfg_rp_fast,
    input  logic [CNT_W-1:0]     cfg_rp_std,
    output logic [NUM_BANKS-1:0] rd_ready,
    output logic [NUM_BANKS-1:0] act_ready
);

    cmd_op_t       op;
    logic          is_act;
    logic          is_pre;
    region_prof_t  wr_prof;
    region_prof_t  look;
    logic [7:0]    rcd_sel;
    logic [7:0]    rp_sel;
    logic [CNT_W-1:0] rcd_val;
    logic [CNT_W-1:0] rp_val;

    assign op     = cmd_op_t'(cmd_op);
    assign is_act = cmd_valid && (op == OP_ACT);
    assign is_pre = cmd_valid && (op == OP_PRE);

    assign wr_prof.rcd_fast = prof_rcd_fast;
    assign wr_prof.rp_fast  = prof_rp_fast;

    rtu_profile_table #(.NUM_REGIONS(NUM_REGIONS)) u_table (
        .clk    (clk),
        .rst    (rst),
        .we     (prof_we),
        .wr_idx (prof_region),
        .wr_prof(wr_prof),
        .rd_idx (cmd_region),
        .rd_prof(look)
    );

    assign rcd_sel = pick_delay(look.rcd_fast, 8'(cfg_rcd_fast), 8'(cfg_rcd_std));
    assign rp_sel  = pick_delay(look.rp_fast,  8'(cfg_rp_fast),  8'(cfg_rp_std));
    assign rcd_val = rcd_sel[CNT_W-1:0];
    assign rp_val  = rp_sel[CNT_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        logic rcd_busy;
        logic rp_busy;

        assign hit = (cmd_bank == BANK_W'(b));

        rtu_delay_counter #(.CNT_W(CNT_W)) u_rcd (
            .clk     (clk),
            .rst     (rst),
            .load    (is_act && hit),
            .load_val(rcd_val),
            .busy    (rcd_busy)
        );

        rtu_delay_counter #(.CNT_W(CNT_W)) u_rp (
            .clk     (clk),
            .rst     (rst),
            .load    (is_pre && hit),
            .load_val(rp_val),
            .busy    (rp_busy)
        );

        assign rd_ready[b]  = !rcd_busy;
        assign act_ready[b] = !rp_busy;
    end

endmodule

// File: rtl/rtu_checker.sv
module rtu_checker #(
    parameter int NUM_BANKS   = 4,
    parameter int NUM_REGIONS = 16,
    parameter int CNT_W       = 4,
    localparam int BANK_W = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [1:0]           cmd_op,
    input logic [BANK_W-1:0]    cmd_bank,
    input logic [CNT_W-1:0]     cfg_rcd_fast,
    input logic [CNT_W-1:0]     cfg_rcd_std,
    input logic [CNT_W-1:0]     cfg_rp_fast,
    input logic [CNT_W-1:0]     cfg_rp_std,
    input logic [NUM_BANKS-1:0] rd_ready,
    input logic [NUM_BANKS-1:0] act_ready
);

    // R1
    reset_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&rd_ready && &act_ready));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        // R2
        act_blocks_read_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && cmd_op == 2'b01 && cmd_bank == BANK_W'(b)
             && cfg_rcd_fast != '0 && cfg_rcd_std != '0) |=> !rd_ready[b]);

        // R4
        pre_blocks_act_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && cmd_op == 2'b11 && cmd_bank == BANK_W'(b)
             && cfg_rp_fast != '0 && cfg_rp_std != '0) |=> !act_ready[b]);

        // R6
        idle_read_stays_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_ready[b] && !(cmd_valid && cmd_op == 2'b01 && cmd_bank == BANK_W'(b)))
            |=> rd_ready[b]);

        // R9
        idle_act_stays_chk: assert property (@(posedge clk) disable iff (rst)
            (act_ready[b] && !(cmd_valid && cmd_op == 2'b11 && cmd_bank == BANK_W'(b)))
            |=> act_ready[b]);
    end

endmodule

bind region_timing_unit rtu_checker #(
    .NUM_BANKS  (NUM_BANKS),
    .NUM_REGIONS(NUM_REGIONS),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cfg_rcd_fast(cfg_rcd_fast),
    .cfg_rcd_std (cfg_rcd_std),
    .cfg_rp_fast (cfg_rp_fast),
    .cfg_rp_std  (cfg_rp_std),
    .rd_ready    (rd_ready),
    .act_ready   (act_ready)
);

// File: tb/region_timing_unit_test.sv
`timescale 1ns/1ps
module region_timing_unit_test;

    localparam int NB = 4;
    localparam int NR = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [1:0]    cmd_bank = '0;
    logic [3:0]    cmd_region = '0;
    logic          prof_we = 1'b0;
    logic [3:0]    prof_region = '0;
    logic          prof_rcd_fast = 1'b0;
    logic          prof_rp_fast = 1'b0;
    logic [CW-1:0] cfg_rcd_fast = 4'd4;
    logic [CW-1:0] cfg_rcd_std  = 4'd6;
    logic [CW-1:0] cfg_rp_fast  = 4'd4;
    logic [CW-1:0] cfg_rp_std   = 4'd6;
    logic [NB-1:0] rd_ready;
    logic [NB-1:0] act_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int    exp_q[$];
    int    got_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    region_timing_unit #(.NUM_BANKS(NB), .NUM_REGIONS(NR), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_region(cmd_region), .prof_we(prof_we),
        .prof_region(prof_region), .prof_rcd_fast(prof_rcd_fast),
        .prof_rp_fast(prof_rp_fast), .cfg_rcd_fast(cfg_rcd_fast),
        .cfg_rcd_std(cfg_rcd_std), .cfg_rp_fast(cfg_rp_fast),
        .cfg_rp_std(cfg_rp_std), .rd_ready(rd_ready), .act_ready(act_ready)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // Monitor: pops measured lengths and compares them with the queued expectations
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    task automatic write_prof(input int region, input bit rcd_f, input bit rp_f);
        prof_we = 1'b1; prof_region = 4'(region);
        prof_rcd_fast = rcd_f; prof_rp_fast = rp_f;
        @(negedge clk);
        prof_we = 1'b0;
    endtask

    // Driver: issues one command, optionally writes the table in the same or next cycle,
    // and measures how many sampled cycles the watched ready output stays low.
    task automatic issue(input bit valid, input logic [1:0] op, input int bank,
                         input int region, input int exp, input string tag,
                         input int wr_when, input int wr_reg, input bit wr_rcd, input bit wr_rp);
        int low = 0;
        int others_low = 0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cmd_valid = valid; cmd_op = op; cmd_bank = 2'(bank); cmd_region = 4'(region);
        if (wr_when == 1) begin
            prof_we = 1'b1; prof_region = 4'(wr_reg);
            prof_rcd_fast = wr_rcd; prof_rp_fast = wr_rp;
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        prof_we = 1'b0;
        if (wr_when == 2) begin
            prof_we = 1'b1; prof_region = 4'(wr_reg);
            prof_rcd_fast = wr_rcd; prof_rp_fast = wr_rp;
        end
        for (int i = 0; i < 32; i++) begin
            logic watched;
            if (op == 2'b01 && valid) watched = rd_ready[bank];
            else if (op == 2'b11 && valid) watched = act_ready[bank];
            else watched = rd_ready[bank] & act_ready[bank];
            for (int b = 0; b < NB; b++) begin
                if (b != bank && (!rd_ready[b] || !act_ready[b])) others_low++;
            end
            if (!watched) low++;
            @(negedge clk);
            prof_we = 1'b0;
        end
        got_q.push_back(low);
        check({tag, " R6 other banks"}, others_low, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 rd_ready after reset", int'(rd_ready), 15);
        check("R1 act_ready after reset", int'(act_ready), 15);
        // R1 R3: default table marks region 3 standard
        issue(1, 2'b01, 0, 3, 6, "R3 std activate", 0, 0, 0, 0);
        // R2: region 3 activate flag fast, precharge flag standard
        write_prof(3, 1, 0);
        issue(1, 2'b01, 1, 3, 4, "R2 fast activate", 0, 0, 0, 0);
        // R5: precharge flag of same region stays standard
        issue(1, 2'b11, 1, 3, 6, "R5 rp ignores rcd flag", 0, 0, 0, 0);
        // R4: region 5 precharge fast, activate standard
        write_prof(5, 0, 1);
        issue(1, 2'b11, 2, 5, 4, "R4 fast precharge", 0, 0, 0, 0);
        issue(1, 2'b01, 2, 5, 6, "R5 rcd ignores rp flag", 0, 0, 0, 0);
        issue(1, 2'b11, 3, 9, 6, "R4 std precharge", 0, 0, 0, 0);
        // R7: write in same cycle as activate does not apply to it
        issue(1, 2'b01, 3, 7, 6, "R7 same-cycle write", 1, 7, 1, 1);
        issue(1, 2'b01, 3, 7, 4, "R7 later command sees write", 0, 0, 0, 0);
        // R7: write during a running countdown keeps its length
        issue(1, 2'b11, 0, 8, 6, "R7 running counter", 2, 8, 1, 1);
        // R8: zero delay
        cfg_rcd_fast = 4'd0;
        issue(1, 2'b01, 1, 8, 0, "R8 zero delay", 0, 0, 0, 0);
        // R3: programmed standard count
        cfg_rcd_std = 4'd9;
        issue(1, 2'b01, 2, 9, 9, "R3 programmed std", 0, 0, 0, 0);
        cfg_rp_fast = 4'd2;
        issue(1, 2'b11, 1, 8, 2, "R4 programmed fast", 0, 0, 0, 0);
        // R9: reads, no-ops and invalid commands change nothing
        issue(1, 2'b10, 0, 3, 0, "R9 read", 0, 0, 0, 0);
        issue(1, 2'b00, 1, 3, 0, "R9 nop", 0, 0, 0, 0);
        issue(0, 2'b01, 2, 3, 0, "R9 invalid activate", 0, 0, 0, 0);
        issue(0, 2'b11, 3, 3, 0, "R9 invalid precharge", 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule